// File: doc/BRIEF.md
# Exception Entry and Privilege Mode Controller

This block sequences privilege changes for a small 32-bit core. It owns the live status word, which holds four condition flags, an IRQ mask, an FIQ mask and a 5-bit mode field. It also holds one saved-status copy for each exception mode. Each cycle it arbitrates among pending exception requests by a fixed priority. The winner switches the mode, banks the previous status, raises the masks and issues a vector address and a link value to the fetch logic.

When no exception is taken, the core may request a return-from-exception, which restores the live status from the current mode's saved copy. It may also write the status word directly to switch modes. Those writes are gated by privilege. The vector base is either zero or the high base, chosen by an input. A privileged mode with user registers (System) can be reached only by a status write.

Top module: `exc_mode_ctrl`

## Requirements
- R1: Mode encodings are user 5'b10000, fast-interrupt 5'b10001, interrupt 5'b10010, supervisor 5'b10011, abort 5'b10111, undefined 5'b11011 and system 5'b11111. mode_o always carries one of these values.
- R2: While rst_n is low, status_o reads 32'h000000D3. This is supervisor mode with I (bit 7) and F (bit 6) set and flags clear. The first clock edge after release takes the reset entry at offset 0x0, with take_o high for one cycle.
- R3: A taken entry sets vector_o to base plus offset. The base is 32'h0 when hivec_i is low and 32'hFFFF0000 when it is high. The offsets are reset 0x0, undefined 0x4, software interrupt 0x8, prefetch abort 0xC, data abort 0x10, IRQ 0x18 and FIQ 0x1C. take_o pulses in the cycle after the accepting edge.
- R4: The priority, highest first, is reset entry, data abort, FIQ, IRQ, prefetch abort, undefined, then software interrupt. Only the winner is taken. Losing pulse requests are dropped.
- R5: FIQ (a level) is taken only while F is clear, and IRQ (a level) only while I is clear. An FIQ can therefore preempt an IRQ handler, but an IRQ never preempts an FIQ handler.
- R6: FIQ entry, both abort entries and the reset entry set I and F. IRQ, undefined and software-interrupt entries set I and leave F unchanged. Flags are kept on every entry.
- R7: Every entry except the reset entry copies the prior status into the target mode's saved copy. spsr_o shows the current mode's saved copy, or zero in user or system mode. All saved copies reset to 32'h000000D3.
- R8: On a taken entry, link_o captures pc_i.
- R9: No exception enters system mode. Entry modes are supervisor (reset and software interrupt), abort (both aborts), undefined, IRQ and FIQ.
- R10: When no exception is taken, rfe_i loads the live status from the current mode's saved copy at the next edge. In user or system mode, rfe_i has no effect.
- R11: In user mode, a status write updates only the flags (bits 31:28). Changes to I, F and mode are discarded.
- R12: In a privileged mode, a status write updates the flags, I (bit 7), F (bit 6) and mode (bits 4:0). A mode value outside R1's list leaves the mode unchanged. Other status bits always read zero.
- R13: An exception taken in the same cycle as rfe_i or wr_en_i wins, and the other request is dropped. rfe_i wins over wr_en_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hivec_i | input | 1 | Select high vector base |
| fiq_i | input | 1 | Fast interrupt request level |
| irq_i | input | 1 | Normal interrupt request level |
| swi_i | input | 1 | Software interrupt pulse |
| und_i | input | 1 | Undefined instruction pulse |
| pabt_i | input | 1 | Prefetch abort pulse |
| dabt_i | input | 1 | Data abort pulse |
| pc_i | input | 32 | Return address offered by the core |
| rfe_i | input | 1 | Return-from-exception request |
| wr_en_i | input | 1 | Status write strobe |
| wr_data_i | input | 32 | Status write value |
| status_o | output | 32 | Live status word |
| mode_o | output | 5 | Current mode field |
| spsr_o | output | 32 | Saved status of the current mode |
| take_o | output | 1 | Entry taken pulse |
| vector_o | output | 32 | Entry vector address |
| link_o | output | 32 | Captured return address |

## Verification
Directed sequences separate the cases that the masks and privilege must tell apart. They cover an IRQ handler preempted by FIQ, an IRQ held off inside an FIQ handler, user-mode attempts to raise privilege or return, system mode reached only by a write, and an abort colliding with a status write. Random cycles then present several requests at once, with both vector bases and with writes carrying illegal mode codes. These show that the priority order and the choice between restore and write match the bench's independent model cycle by cycle. Nested entries followed by chains of returns test that each saved copy belongs to its own mode.

// File: rtl/excmode_pkg.sv
package excmode_pkg;

  localparam logic [4:0] M_USR = 5'b10000;
  localparam logic [4:0] M_FIQ = 5'b10001;
  localparam logic [4:0] M_IRQ = 5'b10010;
  localparam logic [4:0] M_SVC = 5'b10011;
  localparam logic [4:0] M_ABT = 5'b10111;
  localparam logic [4:0] M_UND = 5'b11011;
  localparam logic [4:0] M_SYS = 5'b11111;

  localparam int NBANK   = 5;
  localparam int BIDX_W  = $clog2(NBANK);

  // entry kinds, listed in priority order after EV_NONE
  typedef enum logic [2:0] {
    EV_NONE = 3'd0,
    EV_BOOT = 3'd1,
    EV_DABT = 3'd2,
    EV_FIQ  = 3'd3,
    EV_IRQ  = 3'd4,
    EV_PABT = 3'd5,
    EV_UND  = 3'd6,
    EV_SWI  = 3'd7
  } ev_e;

  localparam int NREQ = 7;

  typedef struct packed {
    logic [3:0] flags;
    logic       imask;
    logic       fmask;
    logic [4:0] mode;
  } status_t;

  localparam status_t RESET_STATUS = '{flags: 4'h0, imask: 1'b1, fmask: 1'b1, mode: M_SVC};

  function automatic logic [31:0] pack_status(status_t s);
    return {s.flags, 20'h0, s.imask, s.fmask, 1'b0, s.mode};
  endfunction

  function automatic status_t unpack_status(logic [31:0] w);
    status_t s;
    s.flags = w[31:28];
    s.imask = w[7];
    s.fmask = w[6];
    s.mode  = w[4:0];
    return s;
  endfunction

  function automatic logic mode_legal(logic [4:0] m);
    return (m == M_USR) || (m == M_FIQ) || (m == M_IRQ) || (m == M_SVC) ||
           (m == M_ABT) || (m == M_UND) || (m == M_SYS);
  endfunction

  function automatic logic has_bank(logic [4:0] m);
    return (m == M_FIQ) || (m == M_IRQ) || (m == M_SVC) || (m == M_ABT) || (m == M_UND);
  endfunction

  function automatic logic [BIDX_W-1:0] bank_of(logic [4:0] m);
    case (m)
      M_FIQ:   return BIDX_W'(0);
      M_IRQ:   return BIDX_W'(1);
      M_SVC:   return BIDX_W'(2);
      M_ABT:   return BIDX_W'(3);
      default: return BIDX_W'(4);
    endcase
  endfunction

  function automatic logic [4:0] ev_mode(ev_e e);
    case (e)
      EV_FIQ:           return M_FIQ;
      EV_IRQ:           return M_IRQ;
      EV_DABT, EV_PABT: return M_ABT;
      EV_UND:           return M_UND;
      default:          return M_SVC;
    endcase
  endfunction

  function automatic logic [4:0] ev_offset(ev_e e);
    case (e)
      EV_UND:  return 5'h04;
      EV_SWI:  return 5'h08;
      EV_PABT: return 5'h0C;
      EV_DABT: return 5'h10;
      EV_IRQ:  return 5'h18;
      EV_FIQ:  return 5'h1C;
      default: return 5'h00;
    endcase
  endfunction

  function automatic logic ev_sets_f(ev_e e);
    return (e == EV_BOOT) || (e == EV_FIQ) || (e == EV_DABT) || (e == EV_PABT);
  endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import excmode_pkg::*;
(
  input  logic boot_i,
  input  logic dabt_i,
  input  logic fiq_i,
  input  logic irq_i,
  input  logic pabt_i,
  input  logic und_i,
  input  logic swi_i,
  input  logic imask_i,
  input  logic fmask_i,
  output ev_e  ev_o,
  output logic fire_o
);

  logic [NREQ-1:0] req;
  logic [2:0]      sel;

  assign req = {swi_i, und_i, pabt_i, irq_i & ~imask_i, fiq_i & ~fmask_i, dabt_i, boot_i};

  // lowest index wins: scan from the bottom of the list upward
  always_comb begin
    sel = 3'd0;
    for (int k = NREQ - 1; k >= 0; k--) begin
      if (req[k]) sel = 3'(k);
    end
  end

  assign fire_o = |req;
  assign ev_o   = fire_o ? ev_e'(sel + 3'd1) : EV_NONE;

endmodule

// File: rtl/spsr_bank.sv
module spsr_bank
  import excmode_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [BIDX_W-1:0] widx_i,
  input  logic [WIDTH-1:0]  wdata_i,
  input  logic [BIDX_W-1:0] ridx_i,
  output logic [WIDTH-1:0]  rdata_o
);

  logic [WIDTH-1:0] slot [NBANK];

  for (genvar g = 0; g < NBANK; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              slot[g] <= WIDTH'(pack_status(RESET_STATUS));
      else if (we_i && widx_i == BIDX_W'(g))   slot[g] <= wdata_i;
    end
  end

  assign rdata_o = slot[ridx_i];

endmodule

// File: rtl/exc_mode_ctrl.sv
module exc_mode_ctrl
  import excmode_pkg::*;
#(
  parameter int          ADDR_W  = 32,
  parameter logic [31:0] HI_BASE = 32'hFFFF_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hivec_i,
  input  logic              fiq_i,
  input  logic              irq_i,
  input  logic              swi_i,
  input  logic              und_i,
  input  logic              pabt_i,
  input  logic              dabt_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic              rfe_i,
  input  logic              wr_en_i,
  input  logic [31:0]       wr_data_i,
  output logic [31:0]       status_o,
  output logic [4:0]        mode_o,
  output logic [31:0]       spsr_o,
  output logic              take_o,
  output logic [ADDR_W-1:0] vector_o,
  output logic [ADDR_W-1:0] link_o
);

  status_t           status_q;
  logic              boot_q;
  logic              take_q;
  logic [ADDR_W-1:0] vector_q;
  logic [ADDR_W-1:0] link_q;

  // named internal events
  ev_e               exc_kind;
  logic              exc_fire;
  logic              rfe_go;
  logic              wr_go;
  logic              cur_banked;
  logic [31:0]       saved_word;
  logic [31:0]       status_word;
  logic [ADDR_W-1:0] vec_base;

  exc_arbiter u_arb (
    .boot_i (boot_q),
    .dabt_i (dabt_i),
    .fiq_i  (fiq_i),
    .irq_i  (irq_i),
    .pabt_i (pabt_i),
    .und_i  (und_i),
    .swi_i  (swi_i),
    .imask_i(status_q.imask),
    .fmask_i(status_q.fmask),
    .ev_o   (exc_kind),
    .fire_o (exc_fire)
  );

  assign status_word = pack_status(status_q);
  assign cur_banked  = has_bank(status_q.mode);
  assign rfe_go      = rfe_i && !exc_fire && cur_banked;
  assign wr_go       = wr_en_i && !exc_fire && !rfe_i;
  assign vec_base    = hivec_i ? ADDR_W'(HI_BASE) : '0;

  spsr_bank #(.WIDTH(32)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .we_i   (exc_fire && exc_kind != EV_BOOT),
    .widx_i (bank_of(ev_mode(exc_kind))),
    .wdata_i(status_word),
    .ridx_i (bank_of(status_q.mode)),
    .rdata_o(saved_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= RESET_STATUS;
      boot_q   <= 1'b1;
      take_q   <= 1'b0;
      vector_q <= '0;
      link_q   <= '0;
    end else begin
      boot_q <= 1'b0;
      take_q <= exc_fire;
      if (exc_fire) begin
        status_q.mode  <= ev_mode(exc_kind);
        status_q.imask <= 1'b1;
        if (ev_sets_f(exc_kind)) status_q.fmask <= 1'b1;
        vector_q <= vec_base | ADDR_W'(ev_offset(exc_kind));
        link_q   <= pc_i;
      end else if (rfe_go) begin
        status_q <= unpack_status(saved_word);
      end else if (wr_go) begin
        status_q.flags <= wr_data_i[31:28];
        if (status_q.mode != M_USR) begin
          status_q.imask <= wr_data_i[7];
          status_q.fmask <= wr_data_i[6];
          if (mode_legal(wr_data_i[4:0])) status_q.mode <= wr_data_i[4:0];
        end
      end
    end
  end

  assign status_o = status_word;
  assign mode_o   = status_q.mode;
  assign spsr_o   = cur_banked ? saved_word : 32'h0;
  assign take_o   = take_q;
  assign vector_o = vector_q;
  assign link_o   = link_q;

  // ---------------- assertions ----------------
  p_mode_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mode_legal(mode_o));

  p_irq_needs_unmask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_fire && exc_kind == EV_IRQ) |-> (!status_q.imask && !fiq_i || status_q.fmask || !fiq_i));

  p_fiq_masks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && mode_o == M_FIQ) |-> (status_o[7] && status_o[6]));

  p_no_sys_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (mode_o != M_SYS));

  p_rfe_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rfe_i && !exc_fire && !cur_banked) |=> (status_o == $past(status_o)));

  p_usr_wr_guard_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q.mode == M_USR && wr_en_i && !exc_fire) |=> (status_o[7:0] == $past(status_o[7:0])));

  p_exc_beats_wr_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_fire && wr_en_i) |=> take_o);

endmodule

// File: tb/sim_exc_mode_ctrl.sv
`timescale 1ns/1ps
module sim_exc_mode_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hivec_i = 1'b0, fiq_i = 1'b0, irq_i = 1'b0, swi_i = 1'b0, und_i = 1'b0;
  logic        pabt_i = 1'b0, dabt_i = 1'b0, rfe_i = 1'b0, wr_en_i = 1'b0;
  logic [31:0] pc_i = 32'h0, wr_data_i = 32'h0;
  logic [31:0] status_o, spsr_o, vector_o, link_o;
  logic [4:0]  mode_o;
  logic        take_o;

  always #4 clk = ~clk;

  exc_mode_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .hivec_i(hivec_i), .fiq_i(fiq_i), .irq_i(irq_i),
    .swi_i(swi_i), .und_i(und_i), .pabt_i(pabt_i), .dabt_i(dabt_i), .pc_i(pc_i),
    .rfe_i(rfe_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .status_o(status_o),
    .mode_o(mode_o), .spsr_o(spsr_o), .take_o(take_o), .vector_o(vector_o), .link_o(link_o)
  );

  int n_chk = 0;
  int n_bad = 0;

  // reference model state
  logic [3:0]  m_flags;
  logic        m_i, m_f, m_boot;
  logic [4:0]  m_mode;
  logic [31:0] m_save [5];
  logic        e_take;
  logic [31:0] e_vec, e_link;
  string       auto_tag;

  function automatic logic [31:0] word_of(logic [3:0] fl, logic i, logic f, logic [4:0] m);
    return {fl, 20'h0, i, f, 1'b0, m};
  endfunction

  function automatic int slot_of(logic [4:0] m);
    case (m)
      5'b10001: return 0;
      5'b10010: return 1;
      5'b10011: return 2;
      5'b10111: return 3;
      5'b11011: return 4;
      default:  return -1;
    endcase
  endfunction

  function automatic logic legal(logic [4:0] m);
    return slot_of(m) >= 0 || m == 5'b10000 || m == 5'b11111;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_flags = 4'h0; m_i = 1'b1; m_f = 1'b1; m_mode = 5'b10011; m_boot = 1'b1;
    for (int k = 0; k < 5; k++) m_save[k] = 32'h0000_00D3;
    e_take = 1'b0; e_vec = 32'h0; e_link = 32'h0;
  endtask

  task automatic model_step();
    int          kind;
    logic [31:0] old;
    logic [4:0]  nm;
    logic [31:0] off;
    old  = word_of(m_flags, m_i, m_f, m_mode);
    kind = 0;
    if (m_boot)               kind = 1;
    else if (dabt_i)          kind = 2;
    else if (fiq_i && !m_f)   kind = 3;
    else if (irq_i && !m_i)   kind = 4;
    else if (pabt_i)          kind = 5;
    else if (und_i)           kind = 6;
    else if (swi_i)           kind = 7;
    m_boot = 1'b0;
    if (kind != 0) begin
      case (kind)
        1: begin nm = 5'b10011; off = 32'h00; end
        2: begin nm = 5'b10111; off = 32'h10; end
        3: begin nm = 5'b10001; off = 32'h1C; end
        4: begin nm = 5'b10010; off = 32'h18; end
        5: begin nm = 5'b10111; off = 32'h0C; end
        6: begin nm = 5'b11011; off = 32'h04; end
        default: begin nm = 5'b10011; off = 32'h08; end
      endcase
      if (kind != 1) m_save[slot_of(nm)] = old;
      m_mode = nm;
      m_i = 1'b1;
      if (kind == 1 || kind == 2 || kind == 3 || kind == 5) m_f = 1'b1;
      e_take = 1'b1;
      e_vec  = (hivec_i ? 32'hFFFF_0000 : 32'h0) + off;
      e_link = pc_i;
      auto_tag = (kind == 1) ? "R2" : "R4";
    end else begin
      e_take = 1'b0;
      if (rfe_i) begin
        auto_tag = "R10";
        if (slot_of(m_mode) >= 0) begin
          old = m_save[slot_of(m_mode)];
          m_flags = old[31:28]; m_i = old[7]; m_f = old[6]; m_mode = old[4:0];
        end
      end else if (wr_en_i) begin
        m_flags = wr_data_i[31:28];
        if (m_mode == 5'b10000) auto_tag = "R11";
        else begin
          auto_tag = "R12";
          m_i = wr_data_i[7]; m_f = wr_data_i[6];
          if (legal(wr_data_i[4:0])) m_mode = wr_data_i[4:0];
        end
      end else auto_tag = "R6";
    end
  endtask

  // advance one clock and compare everything; tag overrides the status label
  task automatic step(string tag);
    model_step();
    @(posedge clk);
    #2;
    chk((tag == "") ? auto_tag : tag, status_o, word_of(m_flags, m_i, m_f, m_mode));
    chk("R3", {31'h0, take_o}, {31'h0, e_take});
    chk("R7", spsr_o, (slot_of(m_mode) >= 0) ? m_save[slot_of(m_mode)] : 32'h0);
    if (e_take) begin
      chk("R3", vector_o, e_vec);
      chk("R8", link_o, e_link);
    end
  endtask

  task automatic idle();
    swi_i = 0; und_i = 0; pabt_i = 0; dabt_i = 0; rfe_i = 0; wr_en_i = 0;
  endtask

  initial begin
    #(8 * 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    model_reset();
    #20;
    chk("R2", status_o, 32'h0000_00D3);
    chk("R2", {31'h0, take_o}, 32'h0);
    @(posedge clk); #2;
    rst_n = 1'b1;
    pc_i = 32'h0000_1000;
    step("R2");                                   // reset entry at 0x0
    chk("R2", vector_o, 32'h0);

    // go to user mode with interrupts open
    wr_en_i = 1; wr_data_i = 32'h2000_0010; step("R12"); idle();
    chk("R1", {27'h0, mode_o}, 32'h10);
    // user tries to raise privilege and mask
    wr_en_i = 1; wr_data_i = 32'h5000_00D3; step("R11"); idle();
    chk("R11", status_o, 32'h5000_0010);
    rfe_i = 1; step("R10"); idle();
    chk("R10", status_o, 32'h5000_0010);

    // IRQ then FIQ preempting it
    irq_i = 1; pc_i = 32'h0000_2004; step("R5");
    chk("R1", {27'h0, mode_o}, 32'h12);
    fiq_i = 1; pc_i = 32'h0000_3008; step("R5");
    chk("R1", {27'h0, mode_o}, 32'h11);
    step("R5");                                   // IRQ held off in FIQ handler
    chk("R5", {31'h0, take_o}, 32'h0);
    fiq_i = 0; irq_i = 0;
    rfe_i = 1; step("R10");
    chk("R10", {27'h0, mode_o}, 32'h12);
    step("R10"); idle();
    chk("R10", {27'h0, mode_o}, 32'h10);

    // software interrupt, then system mode by write
    swi_i = 1; hivec_i = 1; step("R9"); idle();
    chk("R3", vector_o, 32'hFFFF_0008);
    wr_en_i = 1; wr_data_i = 32'h0000_00DF; step("R9"); idle();
    chk("R9", {27'h0, mode_o}, 32'h1F);
    rfe_i = 1; step("R10"); idle();
    // illegal mode write keeps mode
    wr_en_i = 1; wr_data_i = 32'h8000_0015; step("R12"); idle();
    chk("R12", {27'h0, mode_o}, 32'h1F);
    // abort collides with a write and a return
    dabt_i = 1; wr_en_i = 1; rfe_i = 1; wr_data_i = 32'h0000_0010; step("R13"); idle();
    chk("R13", {27'h0, mode_o}, 32'h17);
    // undefined and swi together: undefined wins
    und_i = 1; swi_i = 1; hivec_i = 0; step("R4"); idle();
    chk("R4", vector_o, 32'h4);

    // constrained random phase
    void'($urandom(32'h5EED_1234));
    for (int c = 0; c < 4000; c++) begin
      hivec_i   = ($urandom % 2) == 0;
      fiq_i     = ($urandom % 8) == 0;
      irq_i     = ($urandom % 6) == 0;
      dabt_i    = ($urandom % 24) == 0;
      pabt_i    = ($urandom % 24) == 0;
      und_i     = ($urandom % 16) == 0;
      swi_i     = ($urandom % 16) == 0;
      rfe_i     = ($urandom % 5) == 0;
      wr_en_i   = ($urandom % 4) == 0;
      pc_i      = $urandom & 32'hFFFF_FFFC;
      case ($urandom % 9)
        0: wr_data_i = 32'h10; 1: wr_data_i = 32'h11; 2: wr_data_i = 32'h12;
        3: wr_data_i = 32'h13; 4: wr_data_i = 32'h17; 5: wr_data_i = 32'h1B;
        6: wr_data_i = 32'h1F; 7: wr_data_i = 32'h1F; default: wr_data_i = 32'h15;
      endcase
      wr_data_i = wr_data_i | ($urandom & 32'hF000_00C0);
      step("");
    end
    idle(); fiq_i = 0; irq_i = 0;
    step("");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule